// File: doc/BRIEF.md
# Taken-Only Branch Target Buffer

This block is a small fully associative table that sits beside the fetch stage of a simple in-order pipeline. It remembers only branches that were last seen taken, so the presence of an entry is the entire taken prediction. Every cycle the fetch PC is compared with all stored branch addresses. On a hit the next fetch address is the stored target. On a miss fetch falls through to the next sequential instruction.

Each entry can also keep the first instruction word at the branch target. When the entry belongs to an unconditional branch, that word is handed to the pipeline in the branch's own fetch slot, and fetch then continues after the target, so the branch costs no cycles. The execute stage reports every resolved instruction on a resolve port. It gives the PC, whether the instruction was a branch, whether it was taken, whether it was unconditional, whether fetch had hit on it, the actual target and the target instruction word. From these the block adds, refreshes or deletes entries. On a wrong prediction it also runs a two-cycle kill-and-restart sequence.

Top module: `taken_btb`

## Requirements
- R1: While rst_ni is low, every entry becomes invalid and hit_o, fold_o, flush_o and redirect_o are 0; next_pc_o, fold_insn_o and redirect_pc_o are 0.
- R2: If fetch_pc_i matches a valid entry at a clock edge, then after that edge hit_o is 1 and next_pc_o holds the stored target (for an entry that is not folded).
- R3: If fetch_pc_i matches no valid entry at a clock edge, then after that edge hit_o is 0, fold_o is 0 and next_pc_o is fetch_pc_i + INSN_BYTES.
- R4: A resolve with res_valid_i, res_is_branch_i and res_taken_i all 1 writes the PC, the target, the instruction word and the unconditional flag into the table. If that PC is already present, its entry is rewritten in place, so a PC never occupies two entries.
- R5: A resolve that is not a taken branch, for a PC with no entry, leaves the table unchanged.
- R6: A resolve that is not a taken branch, for a PC that has an entry, removes that entry.
- R7: A resolve with res_hit_i = 1 that is a taken branch raises no flush.
- R8: A resolve with res_hit_i = 1 that is not a taken branch raises flush_o for the two cycles after the edge. redirect_o is 0 in the first of those cycles and 1 in the second, and redirect_pc_o = res_pc_i + INSN_BYTES. A new misprediction restarts the sequence.
- R9: A resolve with res_hit_i = 0 that is a taken branch runs the same two-cycle sequence, with redirect_pc_o = res_target_i.
- R10: With FOLD_EN = 1, a hit on an entry written with res_uncond_i = 1 gives fold_o = 1, fold_insn_o equal to the stored word, and next_pc_o equal to the target + INSN_BYTES. In every other case fold_o = 0 and fold_insn_o = 0.
- R11: A new entry takes the lowest-numbered free entry. When no entry is free, it replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such replacement only.
- R12: Table updates take effect at the clock edge, so a lookup in the same cycle as an update sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | PC being fetched this cycle |
| hit_o | output | 1 | Registered: last fetch PC hit a taken entry |
| next_pc_o | output | PC_W | Registered: predicted next fetch address |
| fold_o | output | 1 | Registered: target instruction delivered in branch slot |
| fold_insn_o | output | INSN_W | Registered: folded target instruction word |
| res_valid_i | input | 1 | Resolve report valid |
| res_pc_i | input | PC_W | PC of the resolved instruction |
| res_is_branch_i | input | 1 | Resolved instruction is a branch |
| res_taken_i | input | 1 | Branch was taken |
| res_uncond_i | input | 1 | Branch is unconditional (eligible for folding) |
| res_hit_i | input | 1 | Fetch had hit the table for this instruction |
| res_target_i | input | PC_W | Actual branch target |
| res_target_insn_i | input | INSN_W | Instruction word at the target |
| flush_o | output | 1 | Kill the wrongly fetched work (two cycles) |
| redirect_o | output | 1 | Restart fetch at redirect_pc_o (second flush cycle) |
| redirect_pc_o | output | PC_W | Correct restart address |

## Verification
Scans over a fixed set of fetch PCs, run between resolve events, show whether a report of each kind added, refreshed, removed or left an entry alone. This is how deletion is told apart from no change. A lookup and an allocation of the same PC in one cycle show that the old contents are used. Ten taken branches in a row fill the table and then force replacement. The following fetch scans then show which entries the round-robin pointer evicted. A long pseudo-random mix of branch kinds, taken and not-taken outcomes, folding flags and occasionally wrong res_hit_i values separates correct predictions from both kinds of misprediction, and it also covers a new misprediction landing in the middle of a flush sequence.

// File: rtl/tbtb_pkg.sv
package tbtb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_KILL    = 2'd1,
    SEQ_RESTART = 2'd2
  } seq_e;
endpackage

// File: rtl/tbtb_cam.sv
module tbtb_cam #(
  parameter int N    = 8,
  parameter int PC_W = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]           valid_i,
  input  logic [N-1:0][PC_W-1:0] tag_i,
  input  logic [PC_W-1:0]        key_i,
  output logic [N-1:0]           match_o,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_o[i] = valid_i[i] && (tag_i[i] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match_o;
endmodule

// File: rtl/tbtb_victim.sv
module tbtb_victim #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             full_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign full_o = &valid_i;
  assign idx_o  = full_o ? rr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rr_q <= '0;
    else if (adv_i)  rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/tbtb_seq.sv
module tbtb_seq
  import tbtb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            flush_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] pc_o
);
  seq_e            st_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SEQ_IDLE;
      pc_q <= '0;
    end else if (start_i) begin
      st_q <= SEQ_KILL;
      pc_q <= pc_i;
    end else begin
      unique case (st_q)
        SEQ_KILL:    st_q <= SEQ_RESTART;
        SEQ_RESTART: st_q <= SEQ_IDLE;
        default:     st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign flush_o    = (st_q != SEQ_IDLE);
  assign redirect_o = (st_q == SEQ_RESTART);
  assign pc_o       = pc_q;
endmodule

// File: rtl/taken_btb.sv
module taken_btb #(
  parameter int N_ENTRIES  = 8,
  parameter int PC_W       = 32,
  parameter int INSN_W     = 32,
  parameter int INSN_BYTES = 4,
  parameter bit FOLD_EN    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   fetch_pc_i,
  output logic              hit_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              fold_o,
  output logic [INSN_W-1:0] fold_insn_o,
  input  logic              res_valid_i,
  input  logic [PC_W-1:0]   res_pc_i,
  input  logic              res_is_branch_i,
  input  logic              res_taken_i,
  input  logic              res_uncond_i,
  input  logic              res_hit_i,
  input  logic [PC_W-1:0]   res_target_i,
  input  logic [INSN_W-1:0] res_target_insn_i,
  output logic              flush_o,
  output logic              redirect_o,
  output logic [PC_W-1:0]   redirect_pc_o
);
  localparam int IDX_W = $clog2(N_ENTRIES);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  // entry storage
  logic [N_ENTRIES-1:0]             ent_valid;
  logic [N_ENTRIES-1:0][PC_W-1:0]   ent_tag;
  logic [N_ENTRIES-1:0][PC_W-1:0]   ent_tgt;
  logic [N_ENTRIES-1:0][INSN_W-1:0] ent_insn;
  logic [N_ENTRIES-1:0]             ent_unc;

  // fetch lookup
  logic [N_ENTRIES-1:0] f_match;
  logic                 f_hit;
  logic [IDX_W-1:0]     f_idx;

  tbtb_cam #(.N(N_ENTRIES), .PC_W(PC_W)) u_fetch_cam (
    .valid_i (ent_valid),
    .tag_i   (ent_tag),
    .key_i   (fetch_pc_i),
    .match_o (f_match),
    .hit_o   (f_hit),
    .idx_o   (f_idx)
  );

  // resolve lookup
  logic [N_ENTRIES-1:0] r_match;
  logic                 r_hit;
  logic [IDX_W-1:0]     r_idx;

  tbtb_cam #(.N(N_ENTRIES), .PC_W(PC_W)) u_res_cam (
    .valid_i (ent_valid),
    .tag_i   (ent_tag),
    .key_i   (res_pc_i),
    .match_o (r_match),
    .hit_o   (r_hit),
    .idx_o   (r_idx)
  );

  // update control
  logic             taken_eff;
  logic             wr_en;
  logic             del_en;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] vic_idx;
  logic             tbl_full;
  logic             rr_adv;
  logic [INSN_W-1:0] wr_insn;
  logic             wr_unc;

  assign taken_eff = res_is_branch_i && res_taken_i;
  assign wr_en     = res_valid_i && taken_eff;
  assign del_en    = res_valid_i && !taken_eff && r_hit;
  assign wr_idx    = r_hit ? r_idx : vic_idx;
  assign rr_adv    = wr_en && !r_hit && tbl_full;

  tbtb_victim #(.N(N_ENTRIES)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (ent_valid),
    .adv_i   (rr_adv),
    .idx_o   (vic_idx),
    .full_o  (tbl_full)
  );

  if (FOLD_EN) begin : g_fold
    assign wr_insn = res_target_insn_i;
    assign wr_unc  = res_uncond_i;
  end else begin : g_nofold
    assign wr_insn = '0;
    assign wr_unc  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_valid <= '0;
      ent_tag   <= '0;
      ent_tgt   <= '0;
      ent_insn  <= '0;
      ent_unc   <= '0;
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (wr_en && wr_idx == IDX_W'(i)) begin
          ent_valid[i] <= 1'b1;
          ent_tag[i]   <= res_pc_i;
          ent_tgt[i]   <= res_target_i;
          ent_insn[i]  <= wr_insn;
          ent_unc[i]   <= wr_unc;
        end else if (del_en && r_idx == IDX_W'(i)) begin
          ent_valid[i] <= 1'b0;
        end
      end
    end
  end

  // registered fetch prediction
  logic [PC_W-1:0] f_tgt;
  logic            f_fold;

  assign f_tgt  = ent_tgt[f_idx];
  assign f_fold = f_hit && ent_unc[f_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o       <= 1'b0;
      fold_o      <= 1'b0;
      fold_insn_o <= '0;
      next_pc_o   <= '0;
    end else begin
      hit_o       <= f_hit;
      fold_o      <= f_fold;
      fold_insn_o <= f_fold ? ent_insn[f_idx] : '0;
      if (!f_hit)      next_pc_o <= fetch_pc_i + STEP;
      else if (f_fold) next_pc_o <= f_tgt + STEP;
      else             next_pc_o <= f_tgt;
    end
  end

  // misprediction kill / restart
  logic            mispred;
  logic [PC_W-1:0] fix_pc;

  assign mispred = res_valid_i && (res_hit_i != taken_eff);
  assign fix_pc  = taken_eff ? res_target_i : res_pc_i + STEP;

  tbtb_seq #(.PC_W(PC_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (mispred),
    .pc_i       (fix_pc),
    .flush_o    (flush_o),
    .redirect_o (redirect_o),
    .pc_o       (redirect_pc_o)
  );
endmodule

// File: rtl/taken_btb_chk.sv
module taken_btb_chk #(
  parameter int N_ENTRIES  = 8,
  parameter int PC_W       = 32,
  parameter int INSN_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   fetch_pc_i,
  input logic              hit_o,
  input logic [PC_W-1:0]   next_pc_o,
  input logic              fold_o,
  input logic [INSN_W-1:0] fold_insn_o,
  input logic              res_valid_i,
  input logic [PC_W-1:0]   res_pc_i,
  input logic              res_is_branch_i,
  input logic              res_taken_i,
  input logic              res_hit_i,
  input logic [PC_W-1:0]   res_target_i,
  input logic              flush_o,
  input logic              redirect_o,
  input logic [PC_W-1:0]   redirect_pc_o,
  input logic [N_ENTRIES-1:0] f_match
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  p_unique_tag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(f_match));

  p_miss_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (hit_o || next_pc_o == $past(fetch_pc_i) + STEP));

  p_fold_needs_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fold_o |-> hit_o);

  p_fold_word_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fold_o |-> fold_insn_o == '0);

  p_no_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_hit_i && res_is_branch_i && res_taken_i && !flush_o)
      |=> !flush_o);

  p_kill_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_hit_i && !(res_is_branch_i && res_taken_i))
      |=> (flush_o && !redirect_o && redirect_pc_o == $past(res_pc_i) + STEP));

  p_kill_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_hit_i && res_is_branch_i && res_taken_i)
      |=> (flush_o && !redirect_o && redirect_pc_o == $past(res_target_i)));

  p_restart_second_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (flush_o && $past(flush_o) && !$past(redirect_o)));
endmodule

bind taken_btb taken_btb_chk #(
  .N_ENTRIES  (N_ENTRIES),
  .PC_W       (PC_W),
  .INSN_W     (INSN_W),
  .INSN_BYTES (INSN_BYTES)
) u_chk (.*);

// File: tb/taken_btb_tb_top.sv
`timescale 1ns/1ps
module taken_btb_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        hit_o, fold_o, flush_o, redirect_o;
  logic [31:0] next_pc_o, fold_insn_o, redirect_pc_o;
  logic        res_valid = 0, res_br = 0, res_tk = 0, res_unc = 0, res_hit = 0;
  logic [31:0] res_pc = '0, res_tgt = '0, res_insn = '0;

  always #4 clk = ~clk;

  taken_btb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc),
    .hit_o(hit_o), .next_pc_o(next_pc_o), .fold_o(fold_o), .fold_insn_o(fold_insn_o),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_is_branch_i(res_br),
    .res_taken_i(res_tk), .res_uncond_i(res_unc), .res_hit_i(res_hit),
    .res_target_i(res_tgt), .res_target_insn_i(res_insn),
    .flush_o(flush_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";

  // behavioural reference
  bit          m_v[N];
  logic [31:0] m_tag[N], m_tgt[N], m_insn[N];
  bit          m_unc[N];
  int          m_rr;
  bit          e_hit, e_fold, e_flush, e_redir;
  logic [31:0] e_next, e_finsn, e_rpc;
  int          e_seq;

  function automatic int lookup(logic [31:0] pc);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(e_hit ? "R2 hit_o" : "R3 hit_o", 32'(hit_o), 32'(e_hit));
    chk(e_hit ? "R2 next_pc_o" : "R3 next_pc_o", next_pc_o, e_next);
    chk("R10 fold_o", 32'(fold_o), 32'(e_fold));
    chk("R10 fold_insn_o", fold_insn_o, e_finsn);
    chk("R8 flush_o", 32'(flush_o), 32'(e_flush));
    chk("R8 redirect_o", 32'(redirect_o), 32'(e_redir));
    chk("R9 redirect_pc_o", redirect_pc_o, e_rpc);
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0; e_seq = 0;
    e_hit = 0; e_fold = 0; e_flush = 0; e_redir = 0;
    e_next = '0; e_finsn = '0; e_rpc = '0;
  endtask

  task automatic tick();
    int fi, ri, w;
    bit tk;
    fi = lookup(fetch_pc);
    ri = lookup(res_pc);
    if (fi >= 0) begin
      e_hit = 1; e_fold = m_unc[fi];
      e_finsn = e_fold ? m_insn[fi] : '0;
      e_next  = e_fold ? m_tgt[fi] + 4 : m_tgt[fi];
    end else begin
      e_hit = 0; e_fold = 0; e_finsn = '0; e_next = fetch_pc + 4;
    end
    tk = res_br && res_tk;
    if (res_valid && (res_hit != tk)) begin
      e_seq = 1; e_rpc = tk ? res_tgt : res_pc + 4;
    end else if (e_seq == 1) e_seq = 2;
    else e_seq = 0;
    if (res_valid) begin
      if (tk) begin
        w = ri;
        if (w < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) w = i;
        if (w < 0) begin w = m_rr; m_rr = (m_rr + 1) % N; end
        m_v[w] = 1; m_tag[w] = res_pc; m_tgt[w] = res_tgt;
        m_insn[w] = res_insn; m_unc[w] = res_unc;
      end else if (ri >= 0) m_v[ri] = 0;
    end
    e_flush = (e_seq != 0);
    e_redir = (e_seq == 2);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    res_valid = 0; res_br = 0; res_tk = 0; res_unc = 0; res_hit = 0;
  endtask

  task automatic resolve(logic [31:0] pc, bit br, bit tk, bit unc, bit hit,
                         logic [31:0] tgt, logic [31:0] insn);
    res_valid = 1; res_pc = pc; res_br = br; res_tk = tk; res_unc = unc;
    res_hit = hit; res_tgt = tgt; res_insn = insn;
  endtask

  task automatic scan(logic [31:0] base, int n);
    idle();
    for (int k = 0; k < n; k++) begin fetch_pc = base + 32'(4 * k); tick(); end
  endtask

  task automatic drain();
    idle(); tick(); tick();
  endtask

  initial begin
    repeat (10000000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    phase = "R1"; compare();
    rst_n = 1'b1;
    scan(32'h100, 16);

    phase = "R9";  // taken branch missing from table: allocate + redirect to target
    fetch_pc = 32'h100; resolve(32'h100, 1, 1, 0, 0, 32'h4000, 32'h0); tick(); drain();
    phase = "R4"; scan(32'h100, 4);
    phase = "R2"; fetch_pc = 32'h100; tick();

    phase = "R12"; // same-cycle lookup and allocation of one PC
    fetch_pc = 32'h104; resolve(32'h104, 1, 1, 0, 0, 32'h5000, 32'h0); tick();
    idle(); tick(); tick();

    phase = "R7";  // hit confirmed taken: no flush
    resolve(32'h100, 1, 1, 0, 1, 32'h4000, 32'h0); tick(); drain();

    phase = "R6";  // hit resolved not-taken: kill, restart at pc+4, delete
    resolve(32'h104, 1, 0, 0, 1, 32'h5000, 32'h0); tick(); drain();
    phase = "R8"; scan(32'h100, 4);

    phase = "R5";  // not-taken with no entry: table untouched
    resolve(32'h108, 1, 0, 0, 0, 32'h7000, 32'h0); tick();
    resolve(32'h110, 0, 0, 0, 0, 32'h0, 32'h0); tick();
    scan(32'h100, 16);

    phase = "R10"; // unconditional branch folding
    resolve(32'h10c, 1, 1, 1, 0, 32'h6000, 32'hdeadbeef); tick(); drain();
    fetch_pc = 32'h10c; tick();
    scan(32'h100, 4);

    phase = "R11"; // fill then round-robin replacement
    for (int k = 0; k < 10; k++) begin
      resolve(32'h200 + 32'(4 * k), 1, 1, 0, 0, 32'h9000 + 32'(16 * k), 32'h0);
      tick();
    end
    scan(32'h100, 4);
    scan(32'h200, 12);

    phase = "RND";
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] pc;
      fetch_pc = 32'h100 + 32'(4 * ($urandom % 20));
      if ($urandom % 3 == 0) idle();
      else begin
        pc = 32'h100 + 32'(4 * ($urandom % 20));
        resolve(pc, ($urandom % 8) != 0, $urandom % 2 == 1, $urandom % 4 == 0,
                (lookup(pc) >= 0) ^ ($urandom % 8 == 0),
                32'h8000 + 32'(4 * ($urandom % 16)), $urandom);
      end
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule